// File: doc/BRIEF.md
# Multiplexed Segment Display Frame Serializer

This block refreshes a twelve-position multiplexed segmented display over a four-wire serial link: bit clock, data, and an active-high word enable. The return data line is not used. Software-visible content arrives as flat parallel buses, one slice per position. Each position has a 14-bit segment pattern, three separator bits and one text-label bit. The display also has two unit-indicator bits and four highlight slots, each with a valid bit and a target position. A per-position blink mask selects which characters flash.

The block sends a continuous stream of 32-bit words. Each word powers exactly one position's gate together with the segments for that position. A word starts every `WORD_DIV` system clocks, and sixteen words form one frame: twelve character words followed by four highlight words. A highlight word powers its target character a second time in the same frame, which makes it brighter. Blinking blanks the segments of a character's normal word on alternate blink phases. The highlight word for that character is not blanked.

The content inputs are captured once per frame, so every frame is built from a single consistent snapshot. Bit period, mid-word pause, word interval and blink rate are parameters counted in system clocks or frames.

Top module: `seg_frame_serializer`

## Requirements
- R1: Each word is 32 bits sent MSB first. The receiver samples `sdo_o` on the rising edge of `sclk_o`, and `sdo_o` changes only while `sclk_o` is low or the link is idle. `sen_o` is high for the whole word and low between words, and `sclk_o` is high whenever `sen_o` is low.
- R2: Successive rising edges of `sclk_o` within a word are `2*HALF_DIV` system clocks apart. The one exception is the gap between the 16th and 17th rising edges, which is `2*HALF_DIV+PAUSE_DIV`.
- R3: Word enables rise exactly `WORD_DIV` system clocks apart.
- R4: A frame consists of word slots 0 to 15. Slots 0 to 11 carry character positions 0 to 11, with position 0 leftmost. A character word for position p has bit 31-p set and no other bit of 31..20 set. Bit 19 is the label, bits 18..16 are the separators, segment bits 13..8 go to bits 15..10, and segment bits 7..0 go to bits 7..0. Bits 9..8 are zero.
- R5: The word for position 11 (rightmost) carries the two unit-indicator bits in bits 9..8. Its separator field carries that position's own three separator inputs.
- R6: Slots 12 to 15 are highlight slots 0 to 3. If a slot is valid and its target t is below 12, the word contains only gate bit 31-t and the unblanked segments of position t. Otherwise the whole word is zero.
- R7: Frame f (counted from 0 after reset) is in blink phase `(f / BLINK_FRAMES) mod 2`. In phase 1, a character word whose blink mask bit is set has all segment bits zero, while its gate, label, separator and unit bits are unchanged.
- R8: All content inputs for frame f+1 are sampled in the cycle in which word 15 of frame f starts. Frame 0 uses the values present in the cycle before its first word. Input changes during a frame never alter the words of that frame.
- R9: During and after reset, until the first word, `sen_o` is low and `sclk_o` and `sdo_o` are high. The first word sent is slot 0 of frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| char_seg_i | input | 168 | 14 segment bits per position, position p at [p*14 +: 14] |
| char_sep_i | input | 36 | 3 separator bits per position, position p at [p*3 +: 3] |
| char_lbl_i | input | 12 | Text-label bit per position, position p at bit p |
| unit_i | input | 2 | Unit-indicator bits for the rightmost position |
| blink_i | input | 12 | Blink mask, position p at bit p |
| hl_valid_i | input | 4 | Highlight slot valid bits, slot j at bit j |
| hl_tgt_i | input | 16 | Highlight target position, slot j at [j*4 +: 4] |
| sclk_o | output | 1 | Serial bit clock, idle high |
| sdo_o | output | 1 | Serial data, MSB first |
| sen_o | output | 1 | Word enable, active high |

## Verification
A content change takes effect only in the frame after the next word-15 start. The bench therefore changes the content buses mid-frame, at the start of slot 4 of frame f, and compares every word of frame f against the pattern of frame f and every word of frame f+1 against the new pattern. Serial timing is measured in system clocks between events observed on the link. Edge gaps are counted from one `sclk_o` rise to the next, and word spacing from one `sen_o` rise to the next, so that no absolute latency is assumed. Each word is reassembled from the sampled rising edges and compared when `sen_o` falls. All link sampling is done on the falling system clock edge.

// File: rtl/segfrm_pkg.sv
// Package: shared word layout for the multiplexed display frame serializer.
// Assumes a fixed 32-bit word with a 12-bit one-hot gate field at the top.
package segfrm_pkg;
    localparam int NUM_POS   = 12;
    localparam int NUM_HL    = 4;
    localparam int WORDS     = NUM_POS + NUM_HL;
    localparam int WORD_W    = 32;
    localparam int SEG_W     = 14;
    localparam int SEP_W     = 3;
    localparam int UNIT_W    = 2;
    localparam int TGT_W     = 4;
    localparam int IDX_W     = $clog2(WORDS);
    localparam int GATE_LSB  = WORD_W - NUM_POS;
    localparam int LBL_BIT   = 19;
    localparam int SEP_LSB   = 16;
    localparam int UNIT_LSB  = 8;

    // Places the 14 segment bits into their split word positions.
    function automatic logic [WORD_W-1:0] pack_seg(input logic [SEG_W-1:0] seg);
        return {16'h0, seg[13:8], 2'b00, seg[7:0]};
    endfunction

    // One-hot gate field for a position, leftmost position on the top bit.
    function automatic logic [NUM_POS-1:0] gate_of(input logic [IDX_W-1:0] pos);
        return NUM_POS'({1'b1, {(NUM_POS-1){1'b0}}} >> pos);
    endfunction
endpackage

// File: rtl/seg_word_timer.sv
// Module: seg_word_timer
// Purpose: emits a one-cycle tick every WORD_DIV system clocks; each tick
// starts one display word. Assumes WORD_DIV >= 2.
module seg_word_timer #(
    parameter int WORD_DIV = 122070
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = $clog2(WORD_DIV);

    logic [CW-1:0] cnt;

    // Free-running word interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt <= '0;
        else if (cnt == CW'(WORD_DIV-1))  cnt <= '0;
        else                              cnt <= cnt + 1'b1;
    end

    assign tick_o = (cnt == CW'(WORD_DIV-1));
endmodule

// File: rtl/seg_frame_build.sv
// Module: seg_frame_build
// Purpose: holds a per-frame snapshot of display content, walks the sixteen
// word slots and composes the 32-bit word for each slot on a tick.
// Assumes ticks are spaced far enough apart for the shifter to finish.
module seg_frame_build
    import segfrm_pkg::*;
#(
    parameter int BLINK_FRAMES = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_i,
    input  logic [NUM_POS*SEG_W-1:0]   char_seg_i,
    input  logic [NUM_POS*SEP_W-1:0]   char_sep_i,
    input  logic [NUM_POS-1:0]         char_lbl_i,
    input  logic [UNIT_W-1:0]          unit_i,
    input  logic [NUM_POS-1:0]         blink_i,
    input  logic [NUM_HL-1:0]          hl_valid_i,
    input  logic [NUM_HL*TGT_W-1:0]    hl_tgt_i,
    output logic [WORD_W-1:0]          word_o,
    output logic                       start_o
);
    localparam int BW = $clog2(BLINK_FRAMES) + 1;
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(WORDS-1);

    logic [NUM_POS*SEG_W-1:0] sh_seg_f;
    logic [NUM_POS*SEP_W-1:0] sh_sep_f;
    logic [NUM_POS-1:0]       sh_lbl;
    logic [UNIT_W-1:0]        sh_unit;
    logic [NUM_POS-1:0]       sh_blink;
    logic [NUM_HL-1:0]        sh_hv;
    logic [NUM_HL*TGT_W-1:0]  sh_tgt_f;

    logic [SEG_W-1:0] sh_seg [NUM_POS];
    logic [SEP_W-1:0] sh_sep [NUM_POS];
    logic [TGT_W-1:0] sh_tgt [NUM_HL];

    logic             started;
    logic [IDX_W-1:0] idx;
    logic [BW-1:0]    frm_cnt;
    logic             phase;
    logic             frame_end;
    logic             load;
    logic [WORD_W-1:0] word_d;

    assign frame_end = tick_i && (idx == LAST_SLOT);
    assign load      = !started || frame_end;

    // Unpack snapshot buses into per-position and per-slot arrays.
    for (genvar p = 0; p < NUM_POS; p++) begin : g_pos
        assign sh_seg[p] = sh_seg_f[p*SEG_W +: SEG_W];
        assign sh_sep[p] = sh_sep_f[p*SEP_W +: SEP_W];
    end
    for (genvar j = 0; j < NUM_HL; j++) begin : g_hl
        assign sh_tgt[j] = sh_tgt_f[j*TGT_W +: TGT_W];
    end

    // Snapshot capture: continuous before the first word, then once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_seg_f <= '0;
            sh_sep_f <= '0;
            sh_lbl   <= '0;
            sh_unit  <= '0;
            sh_blink <= '0;
            sh_hv    <= '0;
            sh_tgt_f <= '0;
        end else if (load) begin
            sh_seg_f <= char_seg_i;
            sh_sep_f <= char_sep_i;
            sh_lbl   <= char_lbl_i;
            sh_unit  <= unit_i;
            sh_blink <= blink_i;
            sh_hv    <= hl_valid_i;
            sh_tgt_f <= hl_tgt_i;
        end
    end

    // Slot walker and start flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started <= 1'b0;
            idx     <= '0;
        end else if (tick_i) begin
            started <= 1'b1;
            idx     <= idx + 1'b1;
        end
    end

    // Blink phase: advances at each frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frm_cnt <= '0;
            phase   <= 1'b0;
        end else if (started && frame_end) begin
            if (frm_cnt == BW'(BLINK_FRAMES-1)) begin
                frm_cnt <= '0;
                phase   <= ~phase;
            end else begin
                frm_cnt <= frm_cnt + 1'b1;
            end
        end
    end

    // Word composition for the current slot from the snapshot.
    always_comb begin
        logic [TGT_W-1:0] tgt;
        logic [SEG_W-1:0] seg_v;
        word_d = '0;
        tgt    = sh_tgt[idx[1:0]];
        seg_v  = '0;
        if (idx < IDX_W'(NUM_POS)) begin
            seg_v = (phase && sh_blink[idx]) ? '0 : sh_seg[idx];
            word_d = pack_seg(seg_v);
            word_d[WORD_W-1:GATE_LSB]          = gate_of(idx);
            word_d[LBL_BIT]                    = sh_lbl[idx];
            word_d[SEP_LSB +: SEP_W]           = sh_sep[idx];
            if (idx == IDX_W'(NUM_POS-1))
                word_d[UNIT_LSB +: UNIT_W]     = sh_unit;
        end else if (sh_hv[idx[1:0]] && (tgt < TGT_W'(NUM_POS))) begin
            word_d = pack_seg(sh_seg[tgt]);
            word_d[WORD_W-1:GATE_LSB]          = gate_of(tgt);
        end
    end

    // Output register: word and start pulse for the shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o  <= '0;
            start_o <= 1'b0;
        end else begin
            start_o <= tick_i;
            if (tick_i) word_o <= word_d;
        end
    end

    // R4
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> idx == $past(idx) + 1'b1);
    // R4
    gate_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $onehot0(word_o[WORD_W-1:GATE_LSB]));
    // R7
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(phase));
    // R8
    snapshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started && !frame_end) |=> ($stable(sh_seg_f) && $stable(sh_blink) && $stable(sh_tgt_f)));
endmodule

// File: rtl/seg_shift_out.sv
// Module: seg_shift_out
// Purpose: shifts one 32-bit word out MSB first with an idle-high bit clock,
// data changing on the falling edge and a pause after the 16th bit.
// Assumes start_i arrives only while idle; HALF_DIV and PAUSE_DIV >= 1.
module seg_shift_out
    import segfrm_pkg::*;
#(
    parameter int HALF_DIV  = 63,
    parameter int PAUSE_DIV = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              sclk_o,
    output logic              sdo_o,
    output logic              sen_o
);
    localparam int MAXD = (HALF_DIV > PAUSE_DIV) ? HALF_DIV : PAUSE_DIV;
    localparam int CW   = $clog2(MAXD) + 1;
    localparam int BCW  = $clog2(WORD_W);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(WORD_W-1);
    localparam logic [BCW-1:0] MID_BIT  = BCW'(WORD_W/2-1);

    typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH, S_GAP} sh_state_t;

    sh_state_t         state;
    logic [CW-1:0]     cnt;
    logic [BCW-1:0]    bitn;
    logic [WORD_W-1:0] shreg;

    // Serial engine: low half, high half, optional pause, per bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cnt    <= '0;
            bitn   <= '0;
            shreg  <= '0;
            sclk_o <= 1'b1;
            sdo_o  <= 1'b1;
            sen_o  <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (start_i) begin
                    shreg  <= word_i;
                    sdo_o  <= word_i[WORD_W-1];
                    sclk_o <= 1'b0;
                    sen_o  <= 1'b1;
                    bitn   <= '0;
                    cnt    <= '0;
                    state  <= S_LOW;
                end
                S_LOW: begin
                    if (cnt == CW'(HALF_DIV-1)) begin
                        cnt    <= '0;
                        sclk_o <= 1'b1;
                        state  <= S_HIGH;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_HIGH: begin
                    if (cnt == CW'(HALF_DIV-1)) begin
                        cnt <= '0;
                        if (bitn == LAST_BIT) begin
                            sen_o <= 1'b0;
                            sdo_o <= 1'b1;
                            state <= S_IDLE;
                        end else if (bitn == MID_BIT) begin
                            state <= S_GAP;
                        end else begin
                            shreg  <= shreg << 1;
                            sdo_o  <= shreg[WORD_W-2];
                            sclk_o <= 1'b0;
                            bitn   <= bitn + 1'b1;
                            state  <= S_LOW;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (cnt == CW'(PAUSE_DIV-1)) begin
                        cnt    <= '0;
                        shreg  <= shreg << 1;
                        sdo_o  <= shreg[WORD_W-2];
                        sclk_o <= 1'b0;
                        bitn   <= bitn + 1'b1;
                        state  <= S_LOW;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // R1
    data_stable_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> $stable(sdo_o));
    // R1
    clock_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sen_o |-> sclk_o);
    // R3
    no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> state == S_IDLE);
endmodule

// File: rtl/seg_frame_serializer.sv
// Module: seg_frame_serializer (top)
// Purpose: refreshes a 12-position multiplexed segmented display with
// 16-word frames over a clock/data/enable serial link.
// Assumes WORD_DIV > 64*HALF_DIV + PAUSE_DIV + 2.
module seg_frame_serializer
    import segfrm_pkg::*;
#(
    parameter int HALF_DIV     = 63,
    parameter int PAUSE_DIV    = 63,
    parameter int WORD_DIV     = 122070,
    parameter int BLINK_FRAMES = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_POS*SEG_W-1:0]   char_seg_i,
    input  logic [NUM_POS*SEP_W-1:0]   char_sep_i,
    input  logic [NUM_POS-1:0]         char_lbl_i,
    input  logic [UNIT_W-1:0]          unit_i,
    input  logic [NUM_POS-1:0]         blink_i,
    input  logic [NUM_HL-1:0]          hl_valid_i,
    input  logic [NUM_HL*TGT_W-1:0]    hl_tgt_i,
    output logic                       sclk_o,
    output logic                       sdo_o,
    output logic                       sen_o
);
    logic              tick;
    logic              start;
    logic [WORD_W-1:0] word;

    seg_word_timer #(.WORD_DIV(WORD_DIV)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    seg_frame_build #(.BLINK_FRAMES(BLINK_FRAMES)) u_build (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .char_seg_i (char_seg_i),
        .char_sep_i (char_sep_i),
        .char_lbl_i (char_lbl_i),
        .unit_i     (unit_i),
        .blink_i    (blink_i),
        .hl_valid_i (hl_valid_i),
        .hl_tgt_i   (hl_tgt_i),
        .word_o     (word),
        .start_o    (start)
    );

    seg_shift_out #(.HALF_DIV(HALF_DIV), .PAUSE_DIV(PAUSE_DIV)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .word_i  (word),
        .sclk_o  (sclk_o),
        .sdo_o   (sdo_o),
        .sen_o   (sen_o)
    );
endmodule

// File: tb/seg_frame_serializer_bench.sv
module seg_frame_serializer_bench;
    localparam int HALF   = 2;
    localparam int PAUSE  = 3;
    localparam int WDIV   = 160;
    localparam int BLINK  = 2;
    localparam int FRAMES = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [167:0] char_seg;
    logic [35:0]  char_sep;
    logic [11:0]  char_lbl;
    logic [1:0]   unit;
    logic [11:0]  blink;
    logic [3:0]   hl_valid;
    logic [15:0]  hl_tgt;
    logic sclk, sdo, sen;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    seg_frame_serializer #(.HALF_DIV(HALF), .PAUSE_DIV(PAUSE), .WORD_DIV(WDIV),
                           .BLINK_FRAMES(BLINK)) u_seg_frame_serializer (
        .clk(clk), .rst_n(rst_n), .char_seg_i(char_seg), .char_sep_i(char_sep),
        .char_lbl_i(char_lbl), .unit_i(unit), .blink_i(blink),
        .hl_valid_i(hl_valid), .hl_tgt_i(hl_tgt),
        .sclk_o(sclk), .sdo_o(sdo), .sen_o(sen));

    // Content pattern of frame k.
    function automatic logic [13:0] p_seg(int k, int p);
        return 14'((k * 2749 + p * 613 + 77) ^ (p * k * 31));
    endfunction
    function automatic logic [2:0] p_sep(int k, int p);
        return 3'(k + p * 5);
    endfunction
    function automatic logic p_lbl(int k, int p);
        return ((k + p) % 2) == 1;
    endfunction
    function automatic logic [1:0] p_unit(int k);
        return 2'(k + 1);
    endfunction
    function automatic logic [11:0] p_blink(int k);
        return 12'(k * 1237 + 1445);
    endfunction
    function automatic logic p_hv(int k, int j);
        return ((k + j) % 3) != 0;
    endfunction
    function automatic logic [3:0] p_tgt(int k, int j);
        return 4'((k * 5 + j * 7) % 14);
    endfunction

    function automatic logic [31:0] seg_bits(logic [13:0] s);
        return (32'(s[13:8]) << 10) | 32'(s[7:0]);
    endfunction

    // Expected word for slot s of frame k.
    function automatic logic [31:0] exp_word(int k, int s);
        logic [31:0] w;
        logic ph;
        int t;
        w = 0;
        ph = ((k / BLINK) % 2) == 1;
        if (s < 12) begin
            w[31 - s] = 1'b1;
            if (!(ph && p_blink(k)[s])) w |= seg_bits(p_seg(k, s));
            w[19] = p_lbl(k, s);
            w[18:16] = p_sep(k, s);
            if (s == 11) w[9:8] = p_unit(k);
        end else begin
            t = int'(p_tgt(k, s - 12));
            if (p_hv(k, s - 12) && t < 12) begin
                w[31 - t] = 1'b1;
                w |= seg_bits(p_seg(k, t));
            end
        end
        return w;
    endfunction

    task automatic apply(int k);
        for (int p = 0; p < 12; p++) begin
            char_seg[p*14 +: 14] = p_seg(k, p);
            char_sep[p*3 +: 3]   = p_sep(k, p);
            char_lbl[p]          = p_lbl(k, p);
        end
        unit  = p_unit(k);
        blink = p_blink(k);
        for (int j = 0; j < 4; j++) begin
            hl_valid[j]       = p_hv(k, j);
            hl_tgt[j*4 +: 4]  = p_tgt(k, j);
        end
    endtask

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (40000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cyc, last_start, last_rise, bits, wno, frame, slot;
        logic psclk, psen;
        logic [31:0] acc, expw;
        string tag;
        apply(0);
        repeat (5) @(negedge clk);
        // R9: reset state of the link
        check(sen == 1'b0 && sclk == 1'b1 && sdo == 1'b1, "R9 reset idle",
              {29'd0, sen, sclk, sdo}, 32'd3);
        rst_n = 1'b1;
        @(negedge clk);
        check(sen == 1'b0 && sclk == 1'b1 && sdo == 1'b1, "R9 idle after reset",
              {29'd0, sen, sclk, sdo}, 32'd3);
        cyc = 0; last_start = -1; last_rise = 0; bits = 0; wno = 0;
        acc = 0; psclk = sclk; psen = sen;
        while (wno < FRAMES * 16) begin
            @(negedge clk);
            cyc++;
            frame = wno / 16;
            slot  = wno % 16;
            if (sen && !psen) begin
                if (last_start >= 0)
                    check(cyc - last_start == WDIV, "R3 word spacing",
                          32'(cyc - last_start), 32'(WDIV));
                last_start = cyc;
                bits = 0;
                acc = 0;
                // R8: change content mid-frame; takes effect next frame
                if (slot == 4) apply(frame + 1);
            end
            if (sclk && !psclk && sen) begin
                if (bits > 0)
                    check(cyc - last_rise == (bits == 16 ? 2*HALF + PAUSE : 2*HALF),
                          "R2 edge gap", 32'(cyc - last_rise),
                          32'(bits == 16 ? 2*HALF + PAUSE : 2*HALF));
                last_rise = cyc;
                acc = {acc[30:0], sdo};
                bits++;
            end
            if (!sen && psen) begin
                check(bits == 32, "R1 bit count", 32'(bits), 32'd32);
                expw = exp_word(frame, slot);
                if (slot >= 12)             tag = "R6 R8 highlight word";
                else if (slot == 11)        tag = "R5 R7 R8 rightmost word";
                else if (frame == 0 && slot == 0) tag = "R9 R4 first word";
                else                        tag = "R4 R7 R8 character word";
                check(acc == expw, tag, acc, expw);
                if (!sclk) check(1'b0, "R1 clock idle high", {31'd0, sclk}, 32'd1);
                wno++;
            end
            psclk = sclk;
            psen = sen;
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule